// File: doc/BRIEF.md
# UART Interrupt Status and Mask Unit

This block gathers the event sources of a serial port into one level-sensitive interrupt line. It keeps a sticky ten-bit status vector and a ten-bit mask. Five of the status bits follow live level flags from the receive and transmit queues. The other five latch single-cycle event pulses: overrun, framing error, parity error, receive timeout and modem status change.

Software reaches the unit through a small word-indexed register port. The mask has no plain write path. It is changed only by a set-bits address and a clear-bits address. A third address reads the mask back and ignores writes. A fourth address reads the status vector, and a write to it clears the bits written as one. The interrupt output is registered. It is high whenever some status bit is both set and unmasked.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After a synchronous reset the mask is zero, the status vector is zero and `irq` is low.
- R2: Status bit positions are fixed. Bit 0 is receive trigger level reached, bit 1 receive queue empty, bit 2 receive queue full, bit 3 transmit queue empty, bit 4 transmit queue full. Bit 5 is receive overrun, bit 6 framing error, bit 7 parity error, bit 8 receive timeout, bit 9 modem status change. `lvl_flags[i]` feeds bit i and `evt_pulses[j]` feeds bit 5+j.
- R3: A level flag that is high at a clock edge sets its status bit at that edge. The bit stays set after the flag falls, until software clears it.
- R4: An event pulse that is high at a clock edge sets its status bit, and the bit stays set until software clears it.
- R5: A write to index 0 ORs `reg_wdata[9:0]` into the mask.
- R6: A write to index 1 clears each mask bit whose `reg_wdata` bit is one and leaves the other mask bits unchanged.
- R7: A write to index 2 leaves the mask and the status vector unchanged.
- R8: A write to index 3 clears each status bit whose `reg_wdata` bit is one.
- R9: If a hardware set and a software clear reach the same status bit in the same cycle, the bit ends up set.
- R10: `irq` is registered. One clock after an edge, it equals the OR over all bits of (mask AND status) as they stood before that edge.
- R11: `reg_rdata` is combinational. Index 2 returns the mask and index 3 returns the status, both zero-extended to 32 bits. Indices 0 and 1 return zero. Reading changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word index: 0 set mask, 1 clear mask, 2 mask read, 3 status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| lvl_flags | input | 5 | Live level flags, status bits 0 to 4 |
| evt_pulses | input | 5 | Single-cycle event pulses, status bits 5 to 9 |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with its default values: a 32-bit data port and five level plus five event sources. At these values every one of the ten status positions and all four register indices can be reached from the ports.

A behavioural model runs beside the design and is compared every cycle on `irq` and on the read data at the current index. Directed phases cover:
- each source bit on its own;
- sticky retention after a level flag falls;
- a set and a clear landing on the same bit in one cycle;
- writes to the read-only mask index.

A long pseudo-random phase then mixes writes, reads and source activity.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int unsigned LVL_N  = 5;
    localparam int unsigned EVT_N  = 5;
    localparam int unsigned STAT_W = LVL_N + EVT_N;

    typedef enum logic [1:0] {
        SEL_MASK_SET = 2'd0,
        SEL_MASK_CLR = 2'd1,
        SEL_MASK_RD  = 2'd2,
        SEL_STATUS   = 2'd3
    } reg_sel_e;

    typedef logic [STAT_W-1:0] stat_vec_t;

    // Sources packed so the level flags land in the low bits.
    typedef struct packed {
        logic [EVT_N-1:0] evt;
        logic [LVL_N-1:0] lvl;
    } src_t;

    typedef struct packed {
        logic      mask_set;
        logic      mask_clr;
        logic      stat_clr;
        stat_vec_t bits;
    } wr_cmd_t;

    function automatic wr_cmd_t decode_write(logic we, logic [1:0] addr, stat_vec_t bits);
        wr_cmd_t c;
        reg_sel_e sel;
        sel        = reg_sel_e'(addr);
        c.mask_set = we && (sel == SEL_MASK_SET);
        c.mask_clr = we && (sel == SEL_MASK_CLR);
        c.stat_clr = we && (sel == SEL_STATUS);
        c.bits     = bits;
        return c;
    endfunction

endpackage

// File: rtl/uart_irq_mask.sv
module uart_irq_mask
    import uart_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      set_en,
    input  logic      clr_en,
    input  stat_vec_t bits,
    output stat_vec_t mask_o
);

    stat_vec_t mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (set_en) begin
            mask_q <= mask_q | bits;
        end else if (clr_en) begin
            mask_q <= mask_q & ~bits;
        end
    end

    assign mask_o = mask_q;

    a_r5_set_ors: assert property (@(posedge clk) disable iff (rst)
        set_en |=> ((mask_q & $past(bits)) == $past(bits)));

    a_r6_clr_bits: assert property (@(posedge clk) disable iff (rst)
        clr_en |=> ((mask_q & $past(bits)) == '0));

    a_r7_mask_holds: assert property (@(posedge clk) disable iff (rst)
        (!set_en && !clr_en) |=> $stable(mask_q));

endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
    import uart_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  src_t      src,
    input  logic      clr_en,
    input  stat_vec_t bits,
    output stat_vec_t stat_o
);

    stat_vec_t stat_q;
    stat_vec_t set_vec;
    stat_vec_t clr_vec;

    assign set_vec = src;
    assign clr_vec = clr_en ? bits : '0;

    for (genvar i = 0; i < STAT_W; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst) begin
                stat_q[i] <= 1'b0;
            end else begin
                // hardware set takes priority over software clear
                stat_q[i] <= set_vec[i] | (stat_q[i] & ~clr_vec[i]);
            end
        end
    end

    assign stat_o = stat_q;

    a_r3_level_sets: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat_q[LVL_N-1:0] & $past(src.lvl)) == $past(src.lvl)));

    a_r4_event_sets: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat_q[STAT_W-1:LVL_N] & $past(src.evt)) == $past(src.evt)));

    a_r8_clear_bits: assert property (@(posedge clk) disable iff (rst)
        (clr_en && (src == '0)) |=> ((stat_q & $past(bits)) == '0));

    a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
        clr_en |=> ((stat_q & $past(stat_vec_t'(src))) == $past(stat_vec_t'(src))));

endmodule

// File: rtl/uart_irq_out.sv
module uart_irq_out
    import uart_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  stat_vec_t stat_i,
    input  stat_vec_t mask_i,
    output logic      irq_o
);

    logic irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |(stat_i & mask_i);
        end
    end

    assign irq_o = irq_q;

    a_r1_reset_low: assert property (@(posedge clk)
        rst |=> !irq_o);

    a_r10_registered: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_o == $past(|(stat_i & mask_i))));

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [LVL_N-1:0]  lvl_flags,
    input  logic [EVT_N-1:0]  evt_pulses,
    output logic              irq
);

    localparam int unsigned PAD_W = DATA_W - STAT_W;

    wr_cmd_t   cmd;
    src_t      src;
    stat_vec_t mask_v;
    stat_vec_t stat_v;
    logic      unused_hi;

    assign unused_hi = &{1'b0, reg_wdata[DATA_W-1:STAT_W]};

    assign cmd     = decode_write(reg_we, reg_addr[1:0], reg_wdata[STAT_W-1:0]);
    assign src.lvl = lvl_flags;
    assign src.evt = evt_pulses;

    uart_irq_mask u_mask (
        .clk    (clk),
        .rst    (rst),
        .set_en (cmd.mask_set),
        .clr_en (cmd.mask_clr),
        .bits   (cmd.bits),
        .mask_o (mask_v)
    );

    uart_irq_status u_status (
        .clk    (clk),
        .rst    (rst),
        .src    (src),
        .clr_en (cmd.stat_clr),
        .bits   (cmd.bits),
        .stat_o (stat_v)
    );

    uart_irq_out u_out (
        .clk    (clk),
        .rst    (rst),
        .stat_i (stat_v),
        .mask_i (mask_v),
        .irq_o  (irq)
    );

    always_comb begin
        unique case (reg_sel_e'(reg_addr[1:0]))
            SEL_MASK_RD: reg_rdata = {{PAD_W{1'b0}}, mask_v};
            SEL_STATUS:  reg_rdata = {{PAD_W{1'b0}}, stat_v};
            default:     reg_rdata = '0;
        endcase
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (mask_v == '0));

    a_r11_upper_zero: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[DATA_W-1:STAT_W] == '0);

endmodule

// File: tb/test_uart_irq_ctrl.sv
module test_uart_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [4:0]  lvl_flags = '0;
    logic [4:0]  evt_pulses = '0;
    logic        irq;

    always #2 clk = ~clk;

    uart_irq_ctrl i_uart_irq_ctrl (
        .clk        (clk),
        .rst        (rst),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .lvl_flags  (lvl_flags),
        .evt_pulses (evt_pulses),
        .irq        (irq)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 0;
    bit    armed    = 0;
    string prev_tag = "R1";

    logic [9:0] m_mask = '0;
    logic [9:0] m_stat = '0;
    logic       m_irq  = 1'b0;

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(logic [1:0] a);
        case (a)
            2'd2:    return {22'd0, m_mask};
            2'd3:    return {22'd0, m_stat};
            default: return 32'd0;
        endcase
    endfunction

    // One clock: compare, drive the next inputs, advance the model.
    task automatic cycle(bit r, bit we, logic [1:0] a, logic [31:0] d,
                         logic [4:0] lv, logic [4:0] ev, string tag);
        @(negedge clk);
        if (armed) begin
            check(prev_tag, "irq", {31'd0, irq}, {31'd0, m_irq});
            check(prev_tag, "rdata", reg_rdata, exp_rd(reg_addr));
        end
        rst = r; reg_we = we; reg_addr = a; reg_wdata = d;
        lvl_flags = lv; evt_pulses = ev;
        if (r) begin
            m_mask = '0; m_stat = '0; m_irq = 1'b0;
        end else begin
            m_irq = |(m_mask & m_stat);
            if (we && a == 2'd3) m_stat = m_stat & ~d[9:0];
            m_stat = m_stat | {ev, lv};
            if (we && a == 2'd0) m_mask = m_mask | d[9:0];
            if (we && a == 2'd1) m_mask = m_mask & ~d[9:0];
        end
        armed    = 1;
        prev_tag = tag;
    endtask

    task automatic rd(logic [1:0] a, string tag);
        cycle(0, 0, a, 32'h0, 5'd0, 5'd0, tag);
    endtask

    initial begin
        cycle(1, 0, 2'd3, 0, 0, 0, "R1");
        cycle(1, 0, 2'd2, 0, 0, 0, "R1");
        rd(2'd3, "R1");
        rd(2'd2, "R1");
        // R7: direct mask writes ignored
        cycle(0, 1, 2'd2, 32'hFFFF_FFFF, 0, 0, "R7");
        rd(2'd2, "R7");
        rd(2'd3, "R7");
        // R5: enable ORs
        cycle(0, 1, 2'd0, 32'h005, 0, 0, "R5");
        cycle(0, 1, 2'd0, 32'h300, 0, 0, "R5");
        rd(2'd2, "R5");
        // R2: each level bit alone, then clear
        for (int i = 0; i < 5; i++) begin
            cycle(0, 0, 2'd3, 0, 5'(1 << i), 0, "R2");
            rd(2'd3, "R2");
            cycle(0, 1, 2'd3, 32'h3FF, 0, 0, "R8");
            rd(2'd3, "R8");
        end
        // R4: each event bit alone
        for (int i = 0; i < 5; i++) begin
            cycle(0, 0, 2'd3, 0, 0, 5'(1 << i), "R4");
            rd(2'd3, "R4");
            rd(2'd3, "R4");
            cycle(0, 1, 2'd3, 32'h3FF, 0, 0, "R8");
        end
        // R3: level sticky after falling
        cycle(0, 0, 2'd3, 0, 5'b00100, 0, "R3");
        rd(2'd3, "R3");
        rd(2'd3, "R3");
        // R9: set and clear on same bit
        cycle(0, 1, 2'd3, 32'h3FF, 5'b01000, 5'b00010, "R9");
        rd(2'd3, "R9");
        // R11: reads at 0/1 are zero, repeated reads change nothing
        rd(2'd0, "R11");
        rd(2'd1, "R11");
        rd(2'd3, "R11");
        rd(2'd3, "R11");
        // R6: disable clears selected mask bits
        cycle(0, 1, 2'd1, 32'h104, 0, 0, "R6");
        rd(2'd2, "R6");
        cycle(0, 1, 2'd1, 32'h3FF, 0, 0, "R6");
        rd(2'd2, "R6");
        // R10: irq tracks mask and status
        cycle(0, 1, 2'd0, 32'h040, 0, 0, "R10");
        cycle(0, 0, 2'd3, 0, 0, 5'b00010, "R10");
        rd(2'd3, "R10");
        rd(2'd3, "R10");
        cycle(0, 1, 2'd3, 32'h040, 0, 0, "R10");
        rd(2'd3, "R10");
        rd(2'd3, "R10");
        // mixed pseudo-random phase
        for (int k = 0; k < 2000; k++) begin
            logic [31:0] rv;
            rv = $urandom;
            cycle(0, rv[0], rv[2:1], {22'd0, rv[12:3]},
                  rv[13] ? rv[18:14] : 5'd0, rv[19] ? rv[24:20] : 5'd0, "R10");
        end
        cycle(1, 0, 2'd2, 0, 0, 0, "R1");
        rd(2'd3, "R1");
        rd(2'd2, "R1");
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule